// File: doc/BRIEF.md
# Quarter-Period Hit Sampler

This block finds the quarter of a system clock period in which an asynchronous hit pulse rose. Four clocks share one frequency and are spaced a quarter period apart. The one at zero phase is the system clock. Each clock captures the hit level on its own rising edge, so one system period holds four samples taken at evenly spaced moments.

The four captured bits cross into the system clock domain through a two-register synchronizer. A rising transition is then found by comparing each sample with the one taken just before it. The result is an edge map with one bit per quarter. That map is encoded into a two-bit fine time, and the block emits a one-cycle valid strobe with it. The edge map also leaves the block, so a following Vernier stage knows which quarter boundary to stop at. It then never has to measure more than a quarter period.

A map that is not cleanly one-hot can come from a metastable capture or a glitchy hit. Such a map still produces a result, but it raises an error flag. Once a result has been produced, the block refuses new hits for a fixed number of system cycles.

Top module: `phase_hit_sampler`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `fine_valid`, `fine_err`, `fine_time` and `region_code` are all zero.
- R2: Let E be a rising edge of `clk_0`. The sample of phase k (0..3) is taken at E + k·T/4, and phase 0 is `clk_0` itself. If the hit rises after the sample of phase k-1 and is high at the sample of phase k, the result is `fine_time` = k and `region_code` = only bit k set. For k = 0, the sample before it is the phase-3 sample of the previous period.
- R3: For a hit first seen high at phase k of the period starting at edge E, `fine_valid` is high in the cycle after the third `clk_0` rising edge following E. Each sample passes through two `clk_0` registers before it is decoded.
- R4: `fine_valid` is high for exactly one `clk_0` cycle per accepted hit.
- R5: A hit held high over several periods gives one result only. A new result needs a sample that is low followed by a later sample that is high.
- R6: After a `fine_valid` pulse, any result that would appear less than DEAD_CYCLES (default 3) cycles later is dropped and never reported. A result exactly DEAD_CYCLES cycles later is reported.
- R7: `region_code` bit k is set when sample k is high and the sample before it is low. If more than one bit is set, `fine_err` is 1 and `fine_time` is the lowest set index.
- R8: For a clean hit that is sampled in one quarter and then stays high for the rest of that period, `fine_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_0 | input | 1 | System clock, phase 0; all outputs are in this domain |
| clk_90 | input | 1 | Sampling clock delayed by a quarter period |
| clk_180 | input | 1 | Sampling clock delayed by half a period |
| clk_270 | input | 1 | Sampling clock delayed by three quarter periods |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| hit | input | 1 | Asynchronous hit level to be placed in time |
| fine_time | output | 2 | Index of the quarter in which the hit rose |
| region_code | output | 4 | Edge map, one bit per quarter, for the following Vernier stage |
| fine_valid | output | 1 | One-cycle strobe marking a new result |
| fine_err | output | 1 | Result came from a map with more than one bit set |

## Verification
The embedded properties check four things on every cycle: the strobe never lasts two cycles, strobes stay at least the dead time apart, the reported index always points at a set bit of the map, and it is the lowest such bit. They also check that the error flag agrees with the number of bits in the map. Which quarter a hit lands in, the three-cycle latency, and the one-result-per-rise behaviour for long hits are shown only by the bench scenarios. The same holds for dropping hits inside the lockout window and for the exact glitch that yields a two-bit map. The bench places hit edges in known quarters and predicts each strobe from its own timing model.

// File: rtl/phase_hit_sampler.sv
module phase_hit_sampler #(
  parameter int DEAD_CYCLES = 3
) (
  input  logic       clk_0,
  input  logic       clk_90,
  input  logic       clk_180,
  input  logic       clk_270,
  input  logic       rst_n,
  input  logic       hit,
  output logic [1:0] fine_time,
  output logic [3:0] region_code,
  output logic       fine_valid,
  output logic       fine_err
);

  localparam int QW = (DEAD_CYCLES > 2) ? $clog2(DEAD_CYCLES) : 1;

  logic cap0, cap90, cap180, cap270;
  logic [3:0] sync1, sync2;
  logic       prev_late;
  logic [QW-1:0] quiet;

  always_ff @(posedge clk_0 or negedge rst_n)
    if (!rst_n) cap0 <= 1'b0; else cap0 <= hit;
  always_ff @(posedge clk_90 or negedge rst_n)
    if (!rst_n) cap90 <= 1'b0; else cap90 <= hit;
  always_ff @(posedge clk_180 or negedge rst_n)
    if (!rst_n) cap180 <= 1'b0; else cap180 <= hit;
  always_ff @(posedge clk_270 or negedge rst_n)
    if (!rst_n) cap270 <= 1'b0; else cap270 <= hit;

  always_ff @(posedge clk_0 or negedge rst_n)
    if (!rst_n) begin
      sync1     <= '0;
      sync2     <= '0;
      prev_late <= 1'b0;
    end else begin
      sync1     <= {cap270, cap180, cap90, cap0};
      sync2     <= sync1;
      prev_late <= sync2[3];
    end

  wire [3:0] edge_hot = sync2 & ~{sync2[2:0], prev_late};
  wire       multi    = |(edge_hot & (edge_hot - 4'd1));
  wire       accept   = (|edge_hot) && (quiet == '0);

  logic [1:0] low_idx;
  always_comb begin
    low_idx = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (edge_hot[i]) low_idx = 2'(i);
  end

  always_ff @(posedge clk_0 or negedge rst_n)
    if (!rst_n) begin
      fine_valid  <= 1'b0;
      fine_time   <= '0;
      region_code <= '0;
      fine_err    <= 1'b0;
      quiet       <= '0;
    end else begin
      fine_valid <= accept;
      if (accept) begin
        fine_time   <= low_idx;
        region_code <= edge_hot;
        fine_err    <= multi;
        quiet       <= QW'(DEAD_CYCLES - 1);
      end else if (quiet != '0) begin
        quiet <= quiet - 1'b1;
      end
    end

  a_r4_single_pulse: assert property (@(posedge clk_0) disable iff (!rst_n)
    fine_valid |=> !fine_valid);

  a_r2_index_in_map: assert property (@(posedge clk_0) disable iff (!rst_n)
    fine_valid |-> region_code[fine_time]);

  a_r7_lowest_index: assert property (@(posedge clk_0) disable iff (!rst_n)
    fine_valid |-> ((region_code & ((4'd1 << fine_time) - 4'd1)) == 4'd0));

  a_r7_err_matches_map: assert property (@(posedge clk_0) disable iff (!rst_n)
    fine_valid |-> (fine_err == ($countones(region_code) > 1)));

  generate
    if (DEAD_CYCLES >= 3) begin : g_gap
      a_r6_min_gap: assert property (@(posedge clk_0) disable iff (!rst_n)
        fine_valid |-> (!$past(fine_valid) && !$past(fine_valid, 2)));
    end
  endgenerate

endmodule

// File: tb/phase_hit_sampler_bench.sv
`timescale 1ns/100ps
module phase_hit_sampler_bench;

  localparam int DEAD = 3;

  logic clk_0 = 0, clk_90 = 0, clk_180 = 0, clk_270 = 0;
  logic rst_n = 0, hit = 0;
  logic [1:0] fine_time;
  logic [3:0] region_code;
  logic fine_valid, fine_err;

  phase_hit_sampler #(.DEAD_CYCLES(DEAD)) u_phase_hit_sampler (
    .clk_0(clk_0), .clk_90(clk_90), .clk_180(clk_180), .clk_270(clk_270),
    .rst_n(rst_n), .hit(hit), .fine_time(fine_time), .region_code(region_code),
    .fine_valid(fine_valid), .fine_err(fine_err));

  initial forever #2 clk_0 = ~clk_0;
  initial begin #1; forever #2 clk_90 = ~clk_90; end
  initial begin #2; forever #2 clk_180 = ~clk_180; end
  initial begin #3; forever #2 clk_270 = ~clk_270; end

  typedef struct packed {
    int         due;
    logic [1:0] fine;
    logic [3:0] code;
    logic       err;
    int         tag;
  } ev_t;

  ev_t q[$];
  int cyc = 0, checks = 0, errors = 0, last_v = -100;
  bit run = 0, done = 0;

  always @(posedge clk_0) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // reference model: per-cycle comparison against queued predictions
  always @(negedge clk_0) if (run) begin
    bit exp_v;
    ev_t e;
    exp_v = 0;
    e = '0;
    if (q.size() > 0 && q[0].due == cyc) begin
      e = q.pop_front();
      if (cyc - last_v >= DEAD) begin exp_v = 1; last_v = cyc; end
    end
    check(fine_valid == exp_v, $sformatf("R%0d valid", exp_v ? e.tag : 4),
          int'(fine_valid), int'(exp_v));
    if (exp_v && fine_valid) begin
      check(fine_time == e.fine, $sformatf("R%0d fine_time", e.tag), fine_time, e.fine);
      check(region_code == e.code, $sformatf("R%0d region_code", e.tag), region_code, e.code);
      check(fine_err == e.err, $sformatf("R%0d fine_err", e.err ? 7 : 8), fine_err, e.err);
    end
  end

  // hit rising so that phase k sees it first; R2, R3, R8
  task automatic pulse(input int k, input real width, input int tag);
    int n;
    ev_t e;
    @(posedge clk_0);
    #0.5;
    n = cyc;
    if (k > 0) #(real'(k) - 1.0); else #3.0;
    e.due  = n + 3 + ((k == 0) ? 1 : 0);
    e.fine = 2'(k);
    e.code = 4'(1 << k);
    e.err  = 1'b0;
    e.tag  = tag;
    q.push_back(e);
    hit = 1;
    #(width);
    hit = 0;
  endtask

  // high at phase 1, low at phase 2, high at phase 3: two-bit map (R7)
  task automatic glitch();
    int n;
    ev_t e;
    @(posedge clk_0);
    #0.5;
    n = cyc;
    e.due = n + 3; e.fine = 2'd1; e.code = 4'b1010; e.err = 1'b1; e.tag = 7;
    q.push_back(e);
    hit = 1; #1.0; hit = 0; #1.0; hit = 1; #1.0; hit = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_0);
  endtask

  initial begin
    repeat (3) @(negedge clk_0);
    // R1: reset state
    check(fine_valid == 0 && fine_err == 0, "R1 flags in reset", {fine_valid, fine_err}, 0);
    check(fine_time == 0 && region_code == 0, "R1 data in reset", {fine_time, region_code}, 0);
    rst_n = 1;
    @(negedge clk_0);
    check(fine_valid == 0 && region_code == 0, "R1 after release", {fine_valid, region_code}, 0);
    run = 1;

    // R2 R3 R8: each quarter
    for (int k = 0; k < 4; k++) begin
      pulse(k, 2.0, 2);
      idle(8);
    end
    for (int k = 3; k >= 0; k--) begin
      pulse(k, 2.0, 3);
      idle(6);
    end

    // R5: long hit reported once
    pulse(2, 30.0, 5);
    idle(10);

    // R6: second hit inside lockout dropped, then exactly DEAD apart accepted
    pulse(1, 2.0, 6);
    pulse(2, 2.0, 6);
    pulse(3, 2.0, 6);
    idle(8);
    pulse(1, 2.0, 6);
    idle(2);
    pulse(1, 2.0, 6);
    idle(8);

    // R7: non-one-hot map
    glitch();
    idle(8);
    pulse(3, 2.0, 8);
    idle(8);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_0);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: cycles actual %0d expected < %0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule